// File: doc/BRIEF.md
# Way-Predicted Two-Way Set-Associative Cache

This block is a write-back data cache with two ways per set. It cuts the hit time by guessing which way will hit. Each set keeps one bit naming the way used most recently. When a request arrives, only that way's tag is compared, and its line is already steered to the output. If the guess is wrong, the other way's tag is compared in the next cycle. Either way, only one tag comparator is active per cycle.

On a miss in both ways, the block picks a victim. A dirty victim is written to the lower memory as a whole 256-bit line. The missing line is then fetched as a whole 256-bit line and installed. Each response carries a code saying whether it was a fast hit, a slow hit after a wrong guess, or a miss.

The processor side uses a valid/ready request with 32-bit word loads and stores. Only one request is in flight at a time. The memory side issues whole-line reads and writes with a valid/ready request and a single-cycle read response.

Top module: `waypred_cache`

## Requirements
- R1: An address splits into tag = bits [31:11], set index = bits [10:5] (block address modulo 64), word select = bits [4:2]. Word n of a line occupies line bits [32n+31:32n]. Different sets never disturb each other.
- R2: After reset every line is invalid, so the first access to any address reports a miss (kind 2'b11).
- R3: If the predicted way holds the line, the response has kind 2'b01. A request accepted on edge k (valid and ready both high) gets its response valid in the cycle starting at edge k+1.
- R4: If the predicted way misses and the other way holds the line, the response has kind 2'b10 and is valid in the cycle starting at edge k+2.
- R5: On a miss in both ways, exactly one line read is issued, at the 32-byte aligned address of the request. The response returns the requested word of the fetched line with kind 2'b11.
- R6: Every hit and every fill sets the set's prediction to the way just used, so repeating an access reports kind 2'b01.
- R7: The victim is an invalid way if one exists (way 0 before way 1). Otherwise it is the way not used most recently in that set.
- R8: A store marks its line dirty. Evicting a dirty line first issues a line write of its contents at its own aligned address, followed directly by the refill read. Evicting a clean line issues no write.
- R9: A store (hit or miss) replaces only its addressed 32-bit word and returns that word. Later loads see the new value, and the other words of the line are unchanged.
- R10: cpu_req_ready is high only when no request is being handled, and is high after reset. A memory request holds its valid, address and direction until accepted.
- R11: cpu_rsp_valid is qualified by cpu_rsp_kind: it is never 2'b00 on a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address (word aligned) |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | Response present for one cycle |
| cpu_rsp_rdata | output | 32 | Loaded word, or the stored word |
| cpu_rsp_kind | output | 2 | 01 fast hit, 10 slow hit, 11 miss |
| mem_req_valid | output | 1 | Line request to lower memory |
| mem_req_ready | input | 1 | Lower memory accepts the request |
| mem_req_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | 32 | Line-aligned byte address |
| mem_req_wdata | output | 256 | Line being written back |
| mem_rsp_valid | input | 1 | Read line returned |
| mem_rsp_rdata | input | 256 | Returned line |

## Verification
The hardest case to reach from the ports is a slow hit. It needs a set that holds two valid lines while its prediction points at the line not being requested, and the only way to set that up is through a chosen history of misses. The stimulus fills one set with two lines that share an index, then returns to the first line. It goes on to force evictions whose victims depend on that history, one clean and one dirty. The dirty data is then read back through the lower memory model to confirm that the write-back carried the stored word.

// File: rtl/waypred_pkg.sv
`timescale 1ns/1ps
package waypred_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_FAST = 2'd1,
    KIND_SLOW = 2'd2,
    KIND_MISS = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE1,
    ST_PROBE2,
    ST_EVICT,
    ST_FETCH,
    ST_FILL
  } ctl_state_e;
endpackage

// File: rtl/waypred_tag_store.sv
`timescale 1ns/1ps
// Tag, valid and dirty storage for both ways; all ways read at one index.
module waypred_tag_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 21
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W-1:0]      idx,
  output logic [1:0][TAG_W-1:0] rd_tag,
  output logic [1:0]            rd_valid,
  output logic [1:0]            rd_dirty,
  input  logic                  wr_en,
  input  logic                  wr_way,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic                  wr_dirty
);
  localparam int SETS = 1 << IDX_W;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic             sel_wr;

    assign sel_wr = wr_en && (wr_way == 1'(w));

    always_ff @(posedge clk) begin
      if (sel_wr) tag_mem[idx] <= wr_tag;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (sel_wr) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= wr_dirty;
      end
    end

    assign rd_tag[w]   = tag_mem[idx];
    assign rd_valid[w] = valid_q[idx];
    assign rd_dirty[w] = dirty_q[idx];
  end
endmodule

// File: rtl/waypred_data_store.sv
`timescale 1ns/1ps
// Line storage; one way is steered to the read port by rd_way.
module waypred_data_store #(
  parameter int IDX_W  = 6,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              rd_way,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic              wr_way,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int SETS = 1 << IDX_W;

  logic [1:0][LINE_W-1:0] way_line;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [LINE_W-1:0] line_mem [SETS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 1'(w))) line_mem[idx] <= wr_line;
    end

    assign way_line[w] = line_mem[idx];
  end

  assign rd_line = way_line[rd_way];
endmodule

// File: rtl/waypred_set_state.sv
`timescale 1ns/1ps
// One bit per set: the most recently used way, which is also the predicted way.
module waypred_set_state #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic             mru_way,
  input  logic             upd_en,
  input  logic             upd_way
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] mru_q;

  always_ff @(posedge clk) begin
    if (rst) mru_q <= '0;
    else if (upd_en) mru_q[idx] <= upd_way;
  end

  assign mru_way = mru_q[idx];
endmodule

// File: rtl/waypred_cache.sv
`timescale 1ns/1ps
module waypred_cache #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 256,
  parameter int WORD_W = 32,
  parameter int SETS   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [WORD_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [WORD_W-1:0] cpu_rsp_rdata,
  output logic [1:0]        cpu_rsp_kind,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_rdata
);
  import waypred_pkg::*;

  localparam int OFFS_W = $clog2(LINE_W / 8);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;
  localparam int WORDS  = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BSEL_W = $clog2(WORD_W / 8);

  ctl_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [WORD_W-1:0] wdata_q;
  logic              first_q;
  logic              vic_q;
  logic [TAG_W-1:0]  evict_tag_q;

  logic [TAG_W-1:0]  tag_f;
  logic [IDX_W-1:0]  idx_f;
  logic [WSEL_W-1:0] wsel_f;
  logic [BSEL_W-1:0] unused_byte_bits;

  assign tag_f            = addr_q[ADDR_W-1 -: TAG_W];
  assign idx_f            = addr_q[OFFS_W +: IDX_W];
  assign wsel_f           = addr_q[BSEL_W +: WSEL_W];
  assign unused_byte_bits = addr_q[BSEL_W-1:0];

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                 input logic [WSEL_W-1:0] sel,
                                                 input logic [WORD_W-1:0] word);
    logic [LINE_W-1:0] res;
    res = line;
    res[sel*WORD_W +: WORD_W] = word;
    return res;
  endfunction

  function automatic logic [WORD_W-1:0] get_word(input logic [LINE_W-1:0] line,
                                                 input logic [WSEL_W-1:0] sel);
    return line[sel*WORD_W +: WORD_W];
  endfunction

  // storage read side
  logic [1:0][TAG_W-1:0] rd_tag;
  logic [1:0]            rd_valid;
  logic [1:0]            rd_dirty;
  logic [LINE_W-1:0]     rd_line;
  logic                  mru_way;

  // control
  logic              in_probe;
  logic              probe_way;
  logic              data_way;
  logic              probe_hit;
  logic              victim;
  logic              fill_now;
  logic [LINE_W-1:0] hit_line;
  logic [LINE_W-1:0] fill_line;
  logic              st_wr_en;
  logic              st_wr_way;
  logic [LINE_W-1:0] st_wr_line;
  logic              upd_en;

  always_comb begin
    in_probe  = (state_q == ST_PROBE1) || (state_q == ST_PROBE2);
    // a single comparator: predicted way first, the other way one cycle later
    probe_way = (state_q == ST_PROBE2) ? ~first_q : mru_way;
    data_way  = (state_q == ST_EVICT) ? vic_q : probe_way;
    probe_hit = rd_valid[probe_way] && (rd_tag[probe_way] == tag_f);
    if (!rd_valid[0])      victim = 1'b0;
    else if (!rd_valid[1]) victim = 1'b1;
    else                   victim = ~mru_way;
    fill_now   = (state_q == ST_FILL) && mem_rsp_valid;
    hit_line   = we_q ? put_word(rd_line, wsel_f, wdata_q) : rd_line;
    fill_line  = we_q ? put_word(mem_rsp_rdata, wsel_f, wdata_q) : mem_rsp_rdata;
    st_wr_en   = (in_probe && probe_hit && we_q) || fill_now;
    st_wr_way  = fill_now ? vic_q : probe_way;
    st_wr_line = fill_now ? fill_line : hit_line;
    upd_en     = (in_probe && probe_hit) || fill_now;
  end

  waypred_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk      (clk),
    .rst      (rst),
    .idx      (idx_f),
    .rd_tag   (rd_tag),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .wr_en    (st_wr_en),
    .wr_way   (st_wr_way),
    .wr_tag   (tag_f),
    .wr_dirty (we_q)
  );

  waypred_data_store #(.IDX_W(IDX_W), .LINE_W(LINE_W)) lines_i (
    .clk     (clk),
    .idx     (idx_f),
    .rd_way  (data_way),
    .rd_line (rd_line),
    .wr_en   (st_wr_en),
    .wr_way  (st_wr_way),
    .wr_line (st_wr_line)
  );

  waypred_set_state #(.IDX_W(IDX_W)) recency_i (
    .clk     (clk),
    .rst     (rst),
    .idx     (idx_f),
    .mru_way (mru_way),
    .upd_en  (upd_en),
    .upd_way (st_wr_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      addr_q        <= '0;
      we_q          <= 1'b0;
      wdata_q       <= '0;
      first_q       <= 1'b0;
      vic_q         <= 1'b0;
      evict_tag_q   <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
      cpu_rsp_kind  <= KIND_NONE;
    end else begin
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_kind  <= KIND_NONE;
      case (state_q)
        ST_IDLE: begin
          if (cpu_req_valid) begin
            addr_q  <= cpu_req_addr;
            we_q    <= cpu_req_we;
            wdata_q <= cpu_req_wdata;
            state_q <= ST_PROBE1;
          end
        end
        ST_PROBE1: begin
          first_q <= mru_way;
          if (probe_hit) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= get_word(hit_line, wsel_f);
            cpu_rsp_kind  <= KIND_FAST;
            state_q       <= ST_IDLE;
          end else begin
            state_q <= ST_PROBE2;
          end
        end
        ST_PROBE2: begin
          if (probe_hit) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= get_word(hit_line, wsel_f);
            cpu_rsp_kind  <= KIND_SLOW;
            state_q       <= ST_IDLE;
          end else begin
            vic_q       <= victim;
            evict_tag_q <= rd_tag[victim];
            state_q     <= (rd_valid[victim] && rd_dirty[victim]) ? ST_EVICT : ST_FETCH;
          end
        end
        ST_EVICT: if (mem_req_ready) state_q <= ST_FETCH;
        ST_FETCH: if (mem_req_ready) state_q <= ST_FILL;
        ST_FILL: begin
          if (mem_rsp_valid) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= get_word(fill_line, wsel_f);
            cpu_rsp_kind  <= KIND_MISS;
            state_q       <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_EVICT) || (state_q == ST_FETCH);
  assign mem_req_we    = (state_q == ST_EVICT);
  assign mem_req_addr  = (state_q == ST_EVICT) ? {evict_tag_q, idx_f, {OFFS_W{1'b0}}}
                                               : {tag_f, idx_f, {OFFS_W{1'b0}}};
  assign mem_req_wdata = rd_line;

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);

  // R10
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

  // R3
  fast_latency_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid && (cpu_rsp_kind == KIND_FAST) |-> $past(cpu_req_valid && cpu_req_ready, 2));

  // R4
  slow_latency_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid && (cpu_rsp_kind == KIND_SLOW) |-> $past(cpu_req_valid && cpu_req_ready, 3));

  // R8
  writeback_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_we && mem_req_ready |=> mem_req_valid && !mem_req_we);

  // R11
  rsp_kind_coded_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |-> cpu_rsp_kind != KIND_NONE);
endmodule

// File: tb/waypred_cache_tb_top.sv
`timescale 1ns/1ps
module waypred_cache_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_req_valid = 1'b0;
  logic         cpu_req_ready;
  logic         cpu_req_we = 1'b0;
  logic [31:0]  cpu_req_addr = '0;
  logic [31:0]  cpu_req_wdata = '0;
  logic         cpu_rsp_valid;
  logic [31:0]  cpu_rsp_rdata;
  logic [1:0]   cpu_rsp_kind;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic         mem_req_we;
  logic [31:0]  mem_req_addr;
  logic [255:0] mem_req_wdata;
  logic         mem_rsp_valid = 1'b0;
  logic [255:0] mem_rsp_rdata = '0;

  always #2 clk = ~clk;

  waypred_cache dut_i (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_rsp_kind(cpu_rsp_kind),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  localparam logic [1:0] FAST = 2'b01, SLOW = 2'b10, MISS = 2'b11;

  typedef struct {
    logic [31:0] data;
    logic [1:0]  kind;
    int          lat;
    int          t0;
    string       req;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  int rd_cnt = 0, wb_cnt = 0, align_err = 0;
  logic [31:0] last_wb_addr = '0;
  logic [31:0]  ref_mem [logic [31:0]];
  logic [255:0] lower   [logic [31:0]];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk(input logic [20:0] t, input logic [5:0] s, input logic [2:0] w);
    return {t, s, w, 2'b00};
  endfunction

  function automatic logic [31:0] init_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A3C_0F17;
  endfunction

  function automatic logic [31:0] ref_get(input logic [31:0] a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return init_word(a);
  endfunction

  function automatic logic [255:0] lower_get(input logic [31:0] a);
    logic [255:0] l;
    if (lower.exists(a)) return lower[a];
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = init_word(a + 32'(4 * i));
    return l;
  endfunction

  task automatic check32(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // driver: issues one request and pushes its expected response
  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input logic [1:0] k, input string req);
    exp_t e;
    if (we) ref_mem[a] = d;
    e.data = we ? d : ref_get(a);
    e.kind = k;
    e.lat  = (k == FAST) ? 1 : (k == SLOW) ? 2 : 0;
    e.req  = req;
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_we    = we;
    cpu_req_addr  = a;
    cpu_req_wdata = d;
    while (!cpu_req_ready) @(negedge clk);
    e.t0 = cyc + 1;
    sb.push_back(e);
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops and compares as responses appear
  initial begin
    forever begin
      @(negedge clk);
      if (cpu_rsp_valid) begin
        if (sb.size() == 0) begin
          check32("R11", "unexpected response", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check32(e.req, "rdata", cpu_rsp_rdata, e.data);
          check32(e.req, "kind", {30'd0, cpu_rsp_kind}, {30'd0, e.kind});
          if (e.lat > 0) check32(e.req, "latency", 32'(cyc - e.t0), 32'(e.lat));
        end
      end
    end
  end

  // lower memory model
  initial begin
    logic [31:0]  a;
    logic         w;
    logic [255:0] d;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (mem_req_valid) begin
        mem_req_ready = 1'b1;
        a = mem_req_addr;
        w = mem_req_we;
        d = mem_req_wdata;
        if (a[4:0] != 5'd0) align_err++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (w) begin
          lower[a] = d;
          wb_cnt++;
          last_wb_addr = a;
        end else begin
          rd_cnt++;
          repeat (2) @(negedge clk);
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = lower_get(a);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int wb0;
    logic [31:0] a0, b0, c1, g0, h0, d4, e0, f0;
    a0 = mk(21'h00011, 6'd3, 3'd0);
    b0 = mk(21'h00022, 6'd3, 3'd0);
    c1 = mk(21'h00033, 6'd3, 3'd1);
    g0 = mk(21'h00011, 6'd7, 3'd0);
    h0 = mk(21'h1FFFFF, 6'd3, 3'd6);
    d4 = mk(21'h00044, 6'd9, 3'd4);
    e0 = mk(21'h00055, 6'd9, 3'd0);
    f0 = mk(21'h00066, 6'd9, 3'd0);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check32("R10", "ready after reset", {31'd0, cpu_req_ready}, 32'd1);
    check32("R2", "rsp_valid after reset", {31'd0, cpu_rsp_valid}, 32'd0);
    check32("R2", "mem_req_valid after reset", {31'd0, mem_req_valid}, 32'd0);

    access(0, a0, 0, MISS, "R2 cold miss");
    access(0, a0, 0, FAST, "R3 repeat");
    access(0, a0 + 32'd20, 0, FAST, "R1 other word same line");
    access(0, b0, 0, MISS, "R7 invalid way chosen");
    access(0, a0, 0, SLOW, "R4 wrong prediction");
    access(0, a0, 0, FAST, "R6 prediction follows hit");
    access(1, a0 + 32'd8, 32'hCAFE_0001, FAST, "R9 store hit");
    access(0, a0 + 32'd8, 0, FAST, "R9 load after store");
    access(0, a0 + 32'd12, 0, FAST, "R9 neighbour unchanged");
    drain();
    wb0 = wb_cnt;
    access(0, c1, 0, MISS, "R7 LRU victim");
    drain();
    check32("R8", "clean eviction writes", 32'(wb_cnt), 32'(wb0));
    access(0, b0, 0, MISS, "R7 LRU evicts dirty line");
    drain();
    check32("R8", "dirty eviction writes", 32'(wb_cnt), 32'(wb0 + 1));
    check32("R8", "write-back address", last_wb_addr, a0);
    access(0, a0 + 32'd8, 0, MISS, "R8 data survives write-back");
    access(0, g0, 0, MISS, "R1 other set");
    access(0, a0 + 32'd8, 0, FAST, "R1 set isolation");
    access(0, h0, 0, MISS, "R1 high tag bits");
    access(1, d4, 32'hBEEF_0004, MISS, "R9 store miss");
    access(0, d4, 0, FAST, "R9 load after store miss");
    access(0, e0, 0, MISS, "R7 second way");
    drain();
    wb0 = wb_cnt;
    access(0, f0, 0, MISS, "R8 evict store-miss line");
    drain();
    check32("R8", "store-miss line written back", 32'(wb_cnt), 32'(wb0 + 1));
    access(0, d4, 0, MISS, "R8 refetch stored word");
    drain();
    check32("R5", "line reads issued", 32'(rd_cnt), 32'd11);
    check32("R5", "misaligned line requests", 32'(align_err), 32'd0);
    check32("R5", "scoreboard empty", 32'(sb.size()), 32'd0);
    finish_up();
  end
endmodule